// File: doc/BRIEF.md
# Divided-Clock Serial Link Master

This block is the master end of a four-wire synchronous serial link between two chips. It runs entirely on one fast system clock and makes the serial clock itself. A counter divides the system clock by a fixed ratio (six by default), and a register drives the serial clock pin. No logic runs on the serial clock. The points where data is launched and sampled are system-clock cycles that line up with the edges of the generated clock.

A request gives a parallel word with a one-cycle `start` while `busy` is low. The block drops chip select, waits one serial-clock period, then sends the word most significant bit first. MOSI changes in the system cycle that raises the serial clock. MISO is taken at the falling edge. MISO comes from another clock domain, so it passes through a synchronizer chain, and the capture point is moved later by the chain's length. When the last bit is in, chip select rises and `done` pulses for one cycle with the received word on `rx_data`.

Top module: `sclk_div_master`

## Requirements
- R1: After reset, and while idle, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: When `start` is sampled high while idle, `cs_n` goes low and `busy` goes high on that same clock edge. The first `sclk` rising edge comes exactly DIV system cycles later (6 by default).
- R3: Each `sclk` period is DIV system cycles, high for DIV/2 and low for DIV/2. A word produces exactly DATA_W rising edges (8 by default).
- R4: MOSI carries `tx_data` most significant bit first. It changes only on the edge that raises `sclk`.
- R5: Each MISO bit is the value present on the pin at the `sclk` falling edge, taken through a SYNC_STAGES-flop synchronizer (2 by default). The bits fill `rx_data` most significant bit first.
- R6: `done` is high for exactly one cycle, DIV*(DATA_W+1) cycles after the accepting edge (54 by default). In that cycle `rx_data` holds the received word, `cs_n` is back at 1 and `busy` is 0.
- R7: A `start` that arrives while `busy` is high is ignored. The transfer in progress completes unchanged and only one `done` results.
- R8: `cs_n` stays low from acceptance until after the last falling edge. `sclk` is never high while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer; taken only while not busy |
| tx_data | input | DATA_W | Word to send, captured when start is taken |
| busy | output | 1 | High from acceptance until the word completes |
| rx_data | output | DATA_W | Word received on MISO, updated with done |
| done | output | 1 | One-cycle completion strobe |
| sclk | output | 1 | Generated serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in, asynchronous to clk |
| cs_n | output | 1 | Active-low chip select |

## Verification
Several properties are checked by assertions on every cycle. These are the serial clock's high-phase width, that MOSI moves only on a rising serial edge, that the serial clock stays low whenever chip select is released, and that `done` is a single pulse seen only after release. The bench acts as the slave and shows what only whole transfers can show. It checks the bit order on both lines and the exact cycle of the first rising edge and of `done`. It checks that the synchronizer-delayed capture still returns the slave's word, and that a `start` arriving mid-transfer leaves the result untouched.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2
   } sdm_state_e;

endpackage

// File: rtl/sdm_sync.sv
module sdm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sdm_timer.sv
module sdm_timer #(
   parameter int DIV  = 6,
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_lead,
   input  logic in_shift,
   input  logic last_bit,
   output logic sclk,
   output logic lead_done,
   output logic rise_tick,
   output logic fall_tick,
   output logic cap_tick,
   output logic word_end
);

   localparam int HALF = DIV / 2;
   localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] C_END  = CW'(DIV - 1);
   localparam logic [CW-1:0] C_FALL = CW'(HALF - 1);
   localparam logic [CW-1:0] C_CAP  = CW'(HALF - 1 + SYNC);

   generate
      if ((DIV % 2) != 0 || DIV < 4) begin : g_bad_div
         $error("sdm_timer: DIV must be even and at least 4");
      end
      if (SYNC >= HALF) begin : g_bad_sync
         $error("sdm_timer: SYNC must be below DIV/2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          bit_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cnt <= '0;
      else if (!(in_lead || in_shift) || cnt == C_END) cnt <= '0;
      else                                           cnt <= cnt + 1'b1;
   end

   assign lead_done = in_lead  && (cnt == C_END);
   assign bit_end   = in_shift && (cnt == C_END);
   assign fall_tick = in_shift && (cnt == C_FALL);
   assign cap_tick  = in_shift && (cnt == C_CAP);
   assign rise_tick = lead_done || (bit_end && !last_bit);
   assign word_end  = bit_end && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sclk <= 1'b0;
      else if (rise_tick) sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
   end

   // high-phase length monitor for the width check
   logic [CW:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hi_len <= '0;
      else if (sclk) hi_len <= hi_len + 1'b1;
      else           hi_len <= '0;
   end

   a_r3_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_len == (CW+1)'(HALF)));

   a_r3_no_double_event: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_tick && fall_tick));

endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] tx_word,
   input  logic         rise_tick,
   input  logic         cap_tick,
   input  logic         miso_s,
   input  logic         word_end,
   output logic         mosi,
   output logic [W-1:0] rx_word
);

   generate
      if (W < 2) begin : g_bad_width
         $error("sdm_datapath: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] tx_sh;
   logic [W-1:0] rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         mosi  <= 1'b0;
      end else if (load) begin
         tx_sh <= tx_word;
      end else if (rise_tick) begin
         mosi  <= tx_sh[W-1];
         tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh   <= '0;
         rx_word <= '0;
      end else begin
         if (cap_tick) rx_sh   <= {rx_sh[W-2:0], miso_s};
         if (word_end) rx_word <= rx_sh;
      end
   end

   a_r5_no_capture_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_tick && word_end));

endmodule

// File: rtl/sclk_div_master.sv
module sclk_div_master
   import sdm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV         = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_data,
   output logic              busy,
   output logic [DATA_W-1:0] rx_data,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);

   localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

   sdm_state_e    state;
   logic [BW-1:0] bitcnt;
   logic          accept, last_bit, miso_s;
   logic          lead_done, rise_tick, fall_tick, cap_tick, word_end;

   assign accept   = (state == ST_IDLE) && start;
   assign last_bit = (bitcnt == B_LAST);
   assign busy     = (state != ST_IDLE);

   sdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(miso), .q(miso_s)
   );

   sdm_timer #(.DIV(DIV), .SYNC(SYNC_STAGES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_lead   (state == ST_LEAD),
      .in_shift  (state == ST_SHIFT),
      .last_bit  (last_bit),
      .sclk      (sclk),
      .lead_done (lead_done),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .cap_tick  (cap_tick),
      .word_end  (word_end)
   );

   sdm_datapath #(.W(DATA_W)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .tx_word   (tx_data),
      .rise_tick (rise_tick),
      .cap_tick  (cap_tick),
      .miso_s    (miso_s),
      .word_end  (word_end),
      .mosi      (mosi),
      .rx_word   (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cs_n   <= 1'b1;
         done   <= 1'b0;
         bitcnt <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_LEAD;
               cs_n  <= 1'b0;
            end
            ST_LEAD: if (lead_done) begin
               state  <= ST_SHIFT;
               bitcnt <= '0;
            end
            ST_SHIFT: begin
               if (word_end) begin
                  state <= ST_IDLE;
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
               end else if (rise_tick) begin
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   a_r8_sclk_low_when_released: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r4_mosi_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi) |-> $rose(sclk));

   a_r6_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !busy));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> (busy || done));

endmodule

// File: tb/sclk_div_master_bench.sv
module sclk_div_master_bench;

   localparam int W       = 8;
   localparam int DIVR    = 6;
   localparam int END_CYC = DIVR * (W + 1);
   localparam int NVEC    = 6;
   // each entry: {word to send, word the slave returns}
   localparam logic [15:0] VEC [NVEC] = '{
      16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic         busy, done, sclk, mosi, cs_n;
   logic         miso = 1'b0;
   logic [W-1:0] rx_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sclk_div_master #(.DATA_W(W), .DIV(DIVR), .SYNC_STAGES(2)) u_sclk_div_master (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .busy(busy),
      .rx_data(rx_data), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso),
      .cs_n(cs_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] rx, input bit poke);
      logic [W-1:0] got = '0;
      int rises = 0, first_rise = -1, done_at = -1, done_cnt = 0, hi_run = 0;
      int bad_hi = 0, cs_bad = 0;
      bit prev = 1'b0;
      @(negedge clk);
      start = 1'b1; tx_data = tx; miso = 1'b0;
      @(negedge clk);
      start = 1'b0; tx_data = ~tx;
      check(cs_n == 1'b0 && busy == 1'b1, "R2 select on accept", {cs_n, busy}, 2'b01);
      for (int k = 0; k <= END_CYC + 6; k++) begin
         if (k > 0) @(negedge clk);
         if (poke && k == 20) start = 1'b1;
         if (poke && k == 23) start = 1'b0;
         if (sclk && !prev) begin
            rises++;
            if (rises == 1) first_rise = k;
            if (rises <= W) miso = rx[W - rises];
         end
         if (!sclk && prev) begin
            got = {got[W-2:0], mosi};
            if (hi_run != DIVR / 2) bad_hi++;
         end
         if (sclk) hi_run++; else hi_run = 0;
         if (done) begin
            done_cnt++;
            done_at = k;
            check(rx_data == rx, "R5 received word", rx_data, rx);
            check(cs_n && !busy, "R6 released at done", {cs_n, busy}, 2'b10);
         end
         if (k < END_CYC && cs_n) cs_bad++;
         if (cs_n && sclk) cs_bad++;
         prev = sclk;
      end
      check(first_rise == DIVR, "R2 first rise delay", first_rise, DIVR);
      check(rises == W, "R3 rising edge count", rises, W);
      check(bad_hi == 0, "R3 high phase width", bad_hi, 0);
      check(got == tx, "R4 mosi word msb first", got, tx);
      check(done_at == END_CYC, "R6 done cycle", done_at, END_CYC);
      check(done_cnt == 1, poke ? "R7 single done despite start" : "R6 single done",
            done_cnt, 1);
      check(cs_bad == 0, "R8 select window", cs_bad, 0);
      check(cs_n && !sclk && !busy, "R1 idle after word", {cs_n, sclk, busy}, 3'b100);
   endtask

   initial begin
      #400000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && !sclk && !busy && !done, "R1 reset state",
            {cs_n, sclk, busy, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(cs_n && !sclk && !busy && !done, "R1 idle without start",
            {cs_n, sclk, busy, done}, 4'b1000);

      for (int i = 0; i < NVEC; i++) run_xfer(VEC[i][15:8], VEC[i][7:0], 1'b0);

      // R7: start pulsed mid-word with a different word
      run_xfer(8'hC6, 8'h39, 1'b1);
      // back-to-back after a poked word still behaves
      run_xfer(8'h3C, 8'hA5, 1'b0);

      // R1: reset in the middle of a word
      @(negedge clk);
      start = 1'b1; tx_data = 8'hFF;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(cs_n && !sclk && !busy && !done, "R1 reset mid word",
            {cs_n, sclk, busy, done}, 4'b1000);
      rst_n = 1'b1;
      run_xfer(8'h96, 8'h69, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule